// File: doc/BRIEF.md
# PCIe Root Port Interrupt Aggregator

This block gathers the interrupt sources of one PCIe root port into a single status word and merges them into one interrupt line for the host. Four legacy level-sensitive INTx wires appear live in the low status bits. Two port management events, link-up and link-down, are rising-edge events. Each is latched into its own pending flag and stays set until software clears it.

Software sees three word addresses. The first is the status word, where writing 1 clears the latched edge flags. The second sets mask bits and the third clears them; reading either of these returns the current mask. The host line is the registered OR of every pending source that is not masked. The trigger type of each bit is fixed by its position and cannot be configured. At bring-up software masks everything, clears all pending flags and then unmasks the sources it services.

Top module: `pcie_port_irq_agg`

## Requirements
- R1: After reset every mask bit is 1, every edge flag is 0 and `irq_out` is 0.
- R2: A write to address 1 (mask-set) sets each mask bit whose data bit is 1 and leaves mask bits with data 0 unchanged. A read of address 1 or 2 returns the mask.
- R3: A write to address 2 (mask-clear) clears each mask bit whose data bit is 1 and leaves mask bits with data 0 unchanged.
- R4: Status bits 0 to 3 (INTx A to D) equal the current `intx_in` levels in the same cycle. Writing status has no effect on them.
- R5: Status bit 4 (link-up, `evt_in[0]`) and bit 5 (link-down, `evt_in[1]`) are set by a rising edge of their input and stay set after the input falls. An input held high does not set them again.
- R6: Writing status (address 0) with a 1 in an edge bit clears that flag. A 0 leaves it unchanged.
- R7: If a rising edge and a write-1-to-clear hit the same edge bit in the same cycle, the flag stays set.
- R8: Status bits 6 to 31 have no source and read as 0. A read of address 3 returns 0.
- R9: `irq_out` equals the OR over all bits of (status AND NOT mask) sampled at the previous clock edge, which is one cycle of latency.
- R10: Writing all ones to mask-set and then all ones to status leaves every source masked, every edge flag clear and `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| intx_in | input | 4 | Legacy INTx A..D levels, active high |
| evt_in | input | 2 | Edge event inputs: bit 0 link-up, bit 1 link-down |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 mask-set, 2 mask-clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Aggregated interrupt line, registered |

## Verification
The bench builds the block with its default parameters: 32 status bits, four level sources and two edge sources. With these values every source class is in reach, including the unconnected upper bits. A vector table walks masks, level changes, edge events and write-1-to-clear writes together through the shared status word. Directed sequences then cover the one-cycle lag of the interrupt line, a clear that coincides with a new edge, an input held high across a clear, and the mask-all, clear-all bring-up sequence.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS   = 2'd0,
    SEL_MASK_SET = 2'd1,
    SEL_MASK_CLR = 2'd2,
    SEL_RSVD     = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pia_edge_bank.sv
module pia_edge_bank #(
  parameter int unsigned NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [NUM_EVT-1:0] clr_in,
  output logic [NUM_EVT-1:0] rise_o,
  output logic [NUM_EVT-1:0] flag_o
);
  function automatic logic flag_next(input logic flag, input logic rise, input logic clr);
    return rise | (flag & ~clr);
  endfunction

  logic [NUM_EVT-1:0] prev_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign rise_o[i] = evt_in[i] & ~prev_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        flag_o[i] <= 1'b0;
      end else begin
        prev_q[i] <= evt_in[i];
        flag_o[i] <= flag_next(flag_o[i], rise_o[i], clr_in[i]);
      end
    end

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> flag_o[i]); // R5
    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o[i] && clr_in[i]) |=> flag_o[i]); // R7
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_in[i] && !rise_o[i]) |=> !flag_o[i]); // R6
    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[i] && !clr_in[i]) |=> flag_o[i]); // R5
  end
endmodule

// File: rtl/pia_mask_bank.sv
module pia_mask_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] mask_o
);
  function automatic logic [NUM_SRC-1:0] mask_next(
    input logic [NUM_SRC-1:0] cur, input logic [NUM_SRC-1:0] s, input logic [NUM_SRC-1:0] c);
    return (cur & ~c) | s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_o <= '1;
    else        mask_o <= mask_next(mask_o, set_vec, clr_vec);
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((mask_o & $past(set_vec)) == $past(set_vec))); // R2
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_vec) && !(|set_vec)) |=> ((mask_o & $past(clr_vec)) == '0)); // R3
  AST_MASK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_vec) && !(|clr_vec)) |=> $stable(mask_o)); // R2
endmodule

// File: rtl/pia_irq_merge.sv
module pia_irq_merge #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               irq_o
);
  function automatic logic any_live(input logic [NUM_SRC-1:0] s, input logic [NUM_SRC-1:0] m);
    return |(s & ~m);
  endfunction

  logic live;
  assign live = any_live(status_i, mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= live;
  end

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & ~mask_i) == '0) |=> !irq_o); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & ~mask_i) != '0) |=> irq_o); // R9
endmodule

// File: rtl/pcie_port_irq_agg.sv
module pcie_port_irq_agg #(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_LEVEL = 4,
  parameter int unsigned NUM_EVT   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LEVEL-1:0]       intx_in,
  input  logic [NUM_EVT-1:0]         evt_in,
  input  logic                       reg_wr_en,
  input  logic [pia_pkg::ADDR_W-1:0] reg_addr,
  input  logic [NUM_SRC-1:0]         reg_wdata,
  output logic [NUM_SRC-1:0]         reg_rdata,
  output logic                       irq_out
);
  import pia_pkg::*;

  localparam int unsigned EVT_LO = NUM_LEVEL;
  localparam int unsigned EVT_HI = NUM_LEVEL + NUM_EVT;

  reg_sel_e           sel;
  logic               wr_status, wr_set, wr_clr;
  logic [NUM_SRC-1:0] mask_set_vec, mask_clr_vec;
  logic [NUM_EVT-1:0] evt_clr, evt_rise, evt_flag;
  logic [NUM_SRC-1:0] status_word, mask_word;

  assign sel       = reg_sel_e'(reg_addr);
  assign wr_status = reg_wr_en && (sel == SEL_STATUS);
  assign wr_set    = reg_wr_en && (sel == SEL_MASK_SET);
  assign wr_clr    = reg_wr_en && (sel == SEL_MASK_CLR);

  assign mask_set_vec = wr_set ? reg_wdata : '0;
  assign mask_clr_vec = wr_clr ? reg_wdata : '0;
  assign evt_clr      = wr_status ? reg_wdata[EVT_LO +: NUM_EVT] : '0;

  pia_edge_bank #(.NUM_EVT(NUM_EVT)) u_edges (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .clr_in(evt_clr),
    .rise_o(evt_rise), .flag_o(evt_flag));

  pia_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_vec(mask_set_vec), .clr_vec(mask_clr_vec),
    .mask_o(mask_word));

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_stat
    if (b < EVT_LO) begin : g_level
      assign status_word[b] = intx_in[b];
    end else if (b < EVT_HI) begin : g_edge
      assign status_word[b] = evt_flag[b-EVT_LO];
    end else begin : g_none
      assign status_word[b] = 1'b0;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS:   reg_rdata = status_word;
      SEL_MASK_SET,
      SEL_MASK_CLR: reg_rdata = mask_word;
      default:      reg_rdata = '0;
    endcase
  end

  pia_irq_merge #(.NUM_SRC(NUM_SRC)) u_merge (
    .clk(clk), .rst_n(rst_n), .status_i(status_word), .mask_i(mask_word),
    .irq_o(irq_out));

  AST_LEVEL_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && $stable(intx_in)) |=> (status_word[EVT_LO-1:0] == $past(intx_in))); // R4
  AST_BRINGUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && (&reg_wdata) && (&mask_word) && !(|evt_rise)) |=> (evt_flag == '0 && (&mask_word))); // R10
endmodule

// File: tb/tb_pcie_port_irq_agg.sv
module tb_pcie_port_irq_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_in = '0;
  logic [1:0]  evt_in = '0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pcie_port_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .intx_in(intx_in), .evt_in(evt_in),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {intx[4], evt[2], wr, addr[2], wdata[32], exp_status[32], exp_mask[32]}
  localparam logic [104:0] VEC [NV] = '{
    {4'h1, 2'b00, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF}, // R4 level live
    {4'h1, 2'b01, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0011, 32'hFFFF_FFFF}, // R5 link-up edge
    {4'h1, 2'b00, 1'b1, 2'd2, 32'h0000_0011, 32'h0000_0011, 32'hFFFF_FFEE}, // R3 R5 unmask, flag held
    {4'h0, 2'b00, 1'b1, 2'd0, 32'h0000_000F, 32'h0000_0010, 32'hFFFF_FFEE}, // R4 R6 write ignored
    {4'h0, 2'b00, 1'b1, 2'd0, 32'h0000_0010, 32'h0000_0000, 32'hFFFF_FFEE}, // R6 clear link-up
    {4'h8, 2'b10, 1'b1, 2'd1, 32'h0000_0001, 32'h0000_0028, 32'hFFFF_FFEF}, // R2 R5 link-down
    {4'h0, 2'b00, 1'b1, 2'd2, 32'h0000_0020, 32'h0000_0020, 32'hFFFF_FFCF}, // R3
    {4'h2, 2'b00, 1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0000_0002, 32'hFFFF_FFCF}, // R6 R8
    {4'h2, 2'b00, 1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0000}, // R3 R8
    {4'h0, 2'b00, 1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF}  // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d); chk("R1 status after reset", d, 32'h0);
    rd(2'd1, d); chk("R1 mask after reset", d, 32'hFFFF_FFFF);
    chk("R1 irq after reset", {31'b0, irq_out}, 32'h0);
    rd(2'd3, d); chk("R8 reserved address", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [104:0] v;
      v = VEC[i];
      intx_in = v[104:101]; evt_in = v[100:99];
      reg_wr_en = v[98]; reg_addr = v[97:96]; reg_wdata = v[95:64];
      @(posedge clk); @(negedge clk);
      reg_wr_en = 1'b0;
      rd(2'd0, d); chk($sformatf("R4 R5 R6 R8 status vec %0d", i), d, v[63:32]);
      rd(2'd2, d); chk($sformatf("R2 R3 mask vec %0d", i), d, v[31:0]);
      tick();
      chk($sformatf("R9 irq vec %0d", i), {31'b0, irq_out},
          {31'b0, |(v[63:32] & ~v[31:0])});
    end

    // R9: one cycle of latency after unmasking a pending flag
    evt_in = 2'b01; tick();
    wr(2'd2, 32'h0000_0010);
    chk("R9 irq not yet raised", {31'b0, irq_out}, 32'h0);
    tick();
    chk("R9 irq raised one cycle later", {31'b0, irq_out}, 32'h1);

    // R7: edge and clear in the same cycle
    evt_in = 2'b00; tick();
    evt_in = 2'b01;
    wr(2'd0, 32'h0000_0010);
    rd(2'd0, d); chk("R7 edge beats clear", d, 32'h0000_0010);

    // R5/R6: input held high, clear succeeds and no re-trigger
    wr(2'd0, 32'h0000_0010);
    tick();
    rd(2'd0, d); chk("R5 held input no retrigger", d, 32'h0);

    // R10: bring-up sequence with both flags pending
    evt_in = 2'b00; tick();
    evt_in = 2'b11; tick();
    rd(2'd0, d); chk("R5 both flags set", d, 32'h0000_0030);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R10 flags cleared", d, 32'h0);
    rd(2'd1, d); chk("R10 all masked", d, 32'hFFFF_FFFF);
    tick();
    chk("R10 irq low", {31'b0, irq_out}, 32'h0);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule